// File: doc/BRIEF.md
# Upstream Sideband Output Clock Gater

This block sits on the receive side of an upstream sideband channel. It runs in the fast system clock domain. A per-cycle enable marks each period of the upstream serial line clock. From that enable it builds a sideband output clock at one third of the line rate. One pulse in every sixteen is left out, so that the gap lines up with the framing of the upstream stream. The recovered sideband data bits, one or two lanes, are captured only when the generated clock falls. They are therefore steady around each rising edge the downstream logic samples on.

The block also checks the line-clock selection against the bandwidth mode. An illegal pairing raises a configuration-error flag and holds the output clock low. A status pin reports upstream synchronization health in one of two configured styles: a level while the lock is missing, or a single-cycle pulse when the lock comes back after an earlier loss. The status pin stays quiet when the upstream channel is disabled or when a reserved style is selected.

Top module: `sb_up_clkgate`

## Requirements
- R1: During reset and on the first cycle after it, `sb_clk`, `sb_data`, `status` and `cfg_err` are all 0.
- R2: `line_en` is held high, the configuration is legal and reset is over. Then `sb_clk` is high for one line tick out of every three, and the first high tick is the third tick after reset.
- R3: Counting from reset or from the end of a configuration error, the 16th, 32nd and every later multiple-of-16 high phase of `sb_clk` is suppressed: `sb_clk` stays low for that whole 3-tick slot.
- R4: The code `rate_sel` is legal for `bw_full`=1 when it is 00, 01 or 10. It is legal for `bw_full`=0 when it is 00, 10 or 11. `cfg_err` is 1 from the clock edge after an illegal pairing is presented, and 0 from the clock edge after a legal one.
- R5: While a configuration error is registered, `sb_clk` is 0. The divide-by-3 phase and the 16-slot frame count restart from zero, so R2 and R3 hold again from the end of the error.
- R6: `sb_data` loads `rx_bits` only on the edge where `sb_clk` goes from 1 to 0. At every other edge it holds its value, including across suppressed slots and on the edge an error begins.
- R7: With `err_sel`=000 and `up_en`=1, `status` on each edge equals the inverse of `lock` sampled at that edge.
- R8: With `err_sel`=001 and `up_en`=1, `status` is a one-cycle pulse on the edge where `lock` is first seen high again after having been seen low. It fires only once `lock` has been high for a full earlier cycle.
- R9: For `err_sel` values 010 to 111, `status` is 0.
- R10: With `up_en`=0, `status` is 0 on the following edge, whatever `lock` does.
- R11: While `line_en` is 0, `sb_clk` and `sb_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the line clock |
| rst | input | 1 | Synchronous active-high reset |
| line_en | input | 1 | One-cycle tick per upstream line clock period |
| rx_bits | input | LANES | Recovered sideband data bits |
| lock | input | 1 | Upstream synchronization lock indicator |
| up_en | input | 1 | Upstream channel enabled |
| bw_full | input | 1 | Bandwidth mode: 1 full, 0 half |
| rate_sel | input | 2 | Line clock selection code |
| err_sel | input | 3 | Status pin style: 000 loss level, 001 restart pulse, others reserved |
| sb_clk | output | 1 | Generated sideband clock |
| sb_data | output | LANES | Sideband data, updated on falling `sb_clk` |
| status | output | 1 | Active-high synchronization status |
| cfg_err | output | 1 | Illegal rate selection for the bandwidth mode |

## Verification
Two events can land on the same edge: a configuration error beginning, and a falling `sb_clk` that would capture new data. The bench changes `rate_sel` and `bw_full` at pseudo-random offsets while `line_en` ticks, so some errors start exactly on a high slot's last tick. The reference model expects the clock to drop without a data capture in that case. A second overlap is a restart pulse that coincides with a switch of `err_sel`. This is judged by the model computing `status` from the values present at that edge.

// File: rtl/sb_up_pkg.sv
package sb_up_pkg;
  typedef enum logic [2:0] {
    ST_LOSS    = 3'b000,
    ST_RESTART = 3'b001
  } st_mode_e;

  function automatic logic rate_ok(input logic full, input logic [1:0] sel);
    if (full) return (sel != 2'b11);
    else      return (sel != 2'b01);
  endfunction
endpackage

// File: rtl/sb_cfg_check.sv
module sb_cfg_check
  import sb_up_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bw_full,
  input  logic [1:0] rate_sel,
  output logic       bad_now,
  output logic       cfg_err
);
  assign bad_now = !rate_ok(bw_full, rate_sel);

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= bad_now;
  end

  a_r4_err_follows_cfg: assert property (@(posedge clk) disable iff (rst)
    (bw_full && rate_sel == 2'b11) |=> cfg_err);
endmodule

// File: rtl/sb_phase_gen.sv
module sb_phase_gen #(
  parameter int DIV       = 3,
  parameter int FRAME_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic line_en,
  input  logic hold,
  output logic sb_clk,
  output logic fall_tick
);
  localparam int PW = $clog2(DIV);
  localparam int FW = $clog2(FRAME_LEN);
  localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
  localparam logic [FW-1:0] FR_LAST = FW'(FRAME_LEN - 1);

  logic [PW-1:0] ph, ph_n;
  logic [FW-1:0] fr, fr_n;
  logic          adv;

  assign adv       = line_en && !hold;
  assign fall_tick = adv && sb_clk;

  always_comb begin
    ph_n = ph;
    fr_n = fr;
    if (adv) begin
      if (ph == PH_LAST) begin
        ph_n = '0;
        fr_n = (fr == FR_LAST) ? '0 : fr + 1'b1;
      end else begin
        ph_n = ph + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      ph     <= '0;
      fr     <= '0;
      sb_clk <= 1'b0;
    end else begin
      ph     <= ph_n;
      fr     <= fr_n;
      sb_clk <= (ph_n == PH_LAST) && (fr_n != FR_LAST);
    end
  end

  a_r11_clk_needs_tick: assert property (@(posedge clk) disable iff (rst)
    (sb_clk != $past(sb_clk)) |-> ($past(line_en) || $past(hold)));
endmodule

// File: rtl/sb_status.sv
module sb_status
  import sb_up_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lock,
  input  logic       up_en,
  input  logic [2:0] err_sel,
  output logic       status
);
  logic lock_q, ever, regain;

  assign regain = lock && !lock_q && ever;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      ever   <= 1'b0;
      status <= 1'b0;
    end else begin
      lock_q <= lock;
      ever   <= ever | lock_q;
      if (!up_en) status <= 1'b0;
      else begin
        case (err_sel)
          ST_LOSS:    status <= !lock;
          ST_RESTART: status <= regain;
          default:    status <= 1'b0;
        endcase
      end
    end
  end

  a_r9_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
    (err_sel[2:1] != 2'b00) |=> !status);
  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !up_en |=> !status);
  a_r8_pulse_short: assert property (@(posedge clk) disable iff (rst)
    (status && err_sel == 3'b001 && $past(err_sel) == 3'b001 && lock) |=> !(err_sel == 3'b001 && status));
endmodule

// File: rtl/sb_up_clkgate.sv
module sb_up_clkgate #(
  parameter int LANES     = 2,
  parameter int DIV       = 3,
  parameter int FRAME_LEN = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_en,
  input  logic [LANES-1:0] rx_bits,
  input  logic             lock,
  input  logic             up_en,
  input  logic             bw_full,
  input  logic [1:0]       rate_sel,
  input  logic [2:0]       err_sel,
  output logic             sb_clk,
  output logic [LANES-1:0] sb_data,
  output logic             status,
  output logic             cfg_err
);
  logic bad_now, fall_tick;

  sb_cfg_check u_cfg (
    .clk(clk), .rst(rst), .bw_full(bw_full), .rate_sel(rate_sel),
    .bad_now(bad_now), .cfg_err(cfg_err)
  );

  sb_phase_gen #(.DIV(DIV), .FRAME_LEN(FRAME_LEN)) u_ph (
    .clk(clk), .rst(rst), .line_en(line_en), .hold(bad_now),
    .sb_clk(sb_clk), .fall_tick(fall_tick)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)            sb_data[i] <= 1'b0;
      else if (fall_tick) sb_data[i] <= rx_bits[i];
    end
  end

  sb_status u_st (
    .clk(clk), .rst(rst), .lock(lock), .up_en(up_en),
    .err_sel(err_sel), .status(status)
  );

  a_r5_clk_low_on_err: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !sb_clk);
  a_r6_data_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sb_data) |-> $fell(sb_clk));
endmodule

// File: tb/sb_up_clkgate_test.sv
module sb_up_clkgate_test;
  localparam int LANES = 2;

  logic clk = 0, rst = 1, line_en = 0, lock = 0, up_en = 0, bw_full = 1;
  logic [LANES-1:0] rx_bits = '0;
  logic [1:0] rate_sel = 2'b00;
  logic [2:0] err_sel = 3'b000;
  logic sb_clk, status, cfg_err;
  logic [LANES-1:0] sb_data;

  int checks = 0, fails = 0, cycles = 0;

  // reference model state
  int m_ph = 0, m_fr = 0;
  bit m_clk = 0, m_err = 0, m_stat = 0, m_lockq = 0, m_ever = 0;
  logic [LANES-1:0] m_data = '0;

  always #5 clk = ~clk;

  sb_up_clkgate #(.LANES(LANES)) uut (
    .clk(clk), .rst(rst), .line_en(line_en), .rx_bits(rx_bits), .lock(lock),
    .up_en(up_en), .bw_full(bw_full), .rate_sel(rate_sel), .err_sel(err_sel),
    .sb_clk(sb_clk), .sb_data(sb_data), .status(status), .cfg_err(cfg_err)
  );

  always @(posedge clk) begin
    bit bad, regain;
    cycles++;
    bad = bw_full ? (rate_sel == 2'b11) : (rate_sel == 2'b01);
    if (rst) begin
      m_ph = 0; m_fr = 0; m_clk = 0; m_err = 0; m_stat = 0;
      m_lockq = 0; m_ever = 0; m_data = '0;
    end else begin
      m_err = bad;
      if (bad) begin
        m_ph = 0; m_fr = 0; m_clk = 0;
      end else if (line_en) begin
        if (m_clk) m_data = rx_bits;
        m_ph = m_ph + 1;
        if (m_ph == 3) begin m_ph = 0; m_fr = (m_fr + 1) % 16; end
        m_clk = (m_ph == 2) && (m_fr != 15);
      end
      regain = lock && !m_lockq && m_ever;
      if (!up_en) m_stat = 0;
      else if (err_sel == 3'b000) m_stat = !lock;
      else if (err_sel == 3'b001) m_stat = regain;
      else m_stat = 0;
      m_ever = m_ever | m_lockq;
      m_lockq = lock;
    end
  end

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    if (cycles > 0) begin
      chk("R2/R3/R5 sb_clk", {3'b0, sb_clk}, {3'b0, m_clk});
      chk("R6/R11 sb_data", {2'b0, sb_data}, {2'b0, m_data});
      chk("R7/R8/R9/R10 status", {3'b0, status}, {3'b0, m_stat});
      chk("R4 cfg_err", {3'b0, cfg_err}, {3'b0, m_err});
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic run(input int n, input int en_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      line_en = ($urandom % 100) < en_pct;
      rx_bits = LANES'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset", {sb_clk, status, cfg_err, 1'b0}, 4'b0);
    chk("R1 reset data", {2'b0, sb_data}, 4'b0);
    @(negedge clk); #1 rst = 0;
    @(negedge clk);
    chk("R1 first cycle", {sb_clk, status, cfg_err, 1'b0}, 4'b0);
    // R2, R3: steady ticks, full mode
    run(200, 100);
    // R11: sparse ticks
    run(300, 30);
    // R4/R5: all codes in both modes, changes at varied offsets
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        @(negedge clk); #1 bw_full = m[0]; rate_sel = s[1:0];
        run(20 + s * 7 + m * 3, 70);
      end
    end
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); #1 bw_full = $urandom; rate_sel = $urandom;
      run($urandom % 12, 90);
    end
    @(negedge clk); #1 bw_full = 0; rate_sel = 2'b10;
    run(120, 100);
    // R7..R10: status styles with lock activity
    up_en = 1;
    for (int e = 0; e < 8; e++) begin
      @(negedge clk); #1 err_sel = e[2:0];
      for (int j = 0; j < 30; j++) begin
        @(negedge clk); #1 lock = ($urandom % 4) != 0; line_en = $urandom;
      end
    end
    err_sel = 3'b001;
    for (int j = 0; j < 200; j++) begin
      @(negedge clk); #1 lock = ($urandom % 3) != 0;
      if (j % 17 == 0) err_sel = $urandom % 3;
      if (j % 50 == 49) up_en = !up_en;
    end
    @(negedge clk); #1 up_en = 0;
    run(20, 50);
    @(negedge clk); @(negedge clk);
    finish_run();
  end
endmodule